// File: doc/BRIEF.md
# Command Header Method Expander

This block sits after a command-stream parser. It takes one decoded command header and turns it into a sequence of single register-write transactions. The header carries a base method index, a subchannel, an argument count, a submission mode and a short immediate. For each 32-bit argument word that arrives after the header, the block emits one write. Each write carries the method index, the subchannel, the data word and a countdown of the writes still to come in that burst.

The mode sets how the method index moves across the burst. It can step up by one per argument, stay fixed, or use the base for the first argument and base plus one for every later argument. A fourth mode uses no argument words at all and emits the header's immediate as a single write.

Headers, argument words and output writes each use a valid/ready handshake. A new header is taken only after the current burst has fully drained downstream. Header values that cannot be expanded raise a one-cycle error pulse and are dropped.

Top module: `cmd_expander`

## Requirements
- R1: After reset, `hdr_ready_o` is 1, while `out_valid_o`, `arg_ready_o` and `err_o` are 0.
- R2: In stepping mode (mode code 1), argument i of a burst is written to method base + i, wrapping modulo 2^METHOD_W.
- R3: In fixed mode (mode code 3), every argument of the burst is written to the base method.
- R4: In first-then-next mode (mode code 5), argument 0 goes to the base method and every later argument goes to base + 1.
- R5: Write i of an N-argument burst carries a remaining count of N - i - 1, so the last write carries 0.
- R6: In immediate mode (mode code 4), exactly one write is emitted. Its data is the header immediate zero-extended to DATA_W and its remaining count is 0. No argument word is consumed (`arg_ready_o` stays 0).
- R7: A header with a mode code other than 1, 3, 4 or 5 produces a one-cycle `err_o` pulse in the cycle after it is accepted. It produces no write and consumes no argument.
- R8: A first-then-next header with a count of 0 is treated as an error in the same way as R7.
- R9: A stepping or fixed header with a count of 0 produces no write and no error, and `hdr_ready_o` is 1 again in the next cycle.
- R10: `hdr_ready_o` stays 0 from the acceptance of a burst or immediate header until its last write has been accepted downstream. It is 1 in the cycle after that.
- R11: While `out_ready_i` is 0, `arg_ready_o` is 0, and the method, subchannel and remaining count of the pending write are held. No argument word is lost.
- R12: Every write of a burst carries the subchannel of its header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Header offered |
| hdr_ready_o | output | 1 | Header accepted when high with valid |
| hdr_method_i | input | METHOD_W | Base method index |
| hdr_subch_i | input | SUBCH_W | Subchannel |
| hdr_count_i | input | COUNT_W | Argument count |
| hdr_mode_i | input | 3 | Submission mode code |
| hdr_imm_i | input | IMM_W | Immediate for immediate mode |
| arg_valid_i | input | 1 | Argument word offered |
| arg_ready_o | output | 1 | Argument word consumed |
| arg_data_i | input | DATA_W | Argument word |
| out_valid_o | output | 1 | Write transaction valid |
| out_ready_i | input | 1 | Downstream accepts the write |
| out_method_o | output | METHOD_W | Method index of the write |
| out_subch_o | output | SUBCH_W | Subchannel of the write |
| out_data_o | output | DATA_W | Data word of the write |
| out_remaining_o | output | COUNT_W | Writes still to come after this one |
| err_o | output | 1 | One-cycle pulse for a rejected header |

## Verification
Bursts of several lengths run in each of the three argument-carrying modes. The method sequences differ: a ramp, a constant, or one step and then a constant. Comparing them shows that each mode code selects its own stepping rule. One stepping burst starts near the top of the method range so that wrap-around shows up. Single-argument bursts tell the first-write rule apart from the later-write rule. The immediate, empty and rejected headers are each followed by argument words left on offer, so any argument consumed in error is seen at `arg_ready_o`. A stall with `out_ready_i` low in mid-burst, and a second header held on offer during a burst, cover the handshake ordering.

// File: rtl/cmd_expander_pkg.sv
package cmd_expander_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_STEP  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_FIXED = 3'd3;
  localparam logic [MODE_W-1:0] MODE_IMM   = 3'd4;
  localparam logic [MODE_W-1:0] MODE_ONCE  = 3'd5;

  typedef enum logic [1:0] {
    HC_BURST,
    HC_IMM,
    HC_EMPTY,
    HC_BAD
  } hdr_class_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BURST,
    ST_IMM
  } seq_state_e;

endpackage

// File: rtl/cmd_hdr_classify.sv
module cmd_hdr_classify
  import cmd_expander_pkg::*;
#(
  parameter int COUNT_W = 13
) (
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [COUNT_W-1:0] count_i,
  output hdr_class_e         cls_o
);

  logic cnt_zero;
  assign cnt_zero = (count_i == '0);

  always_comb begin
    unique case (mode_i)
      MODE_STEP, MODE_FIXED: cls_o = cnt_zero ? HC_EMPTY : HC_BURST;
      MODE_ONCE:             cls_o = cnt_zero ? HC_BAD   : HC_BURST;
      MODE_IMM:              cls_o = HC_IMM;
      default:               cls_o = HC_BAD;
    endcase
  end

endmodule

// File: rtl/cmd_method_step.sv
module cmd_method_step
  import cmd_expander_pkg::*;
#(
  parameter int METHOD_W = 13,
  parameter int COUNT_W  = 13
) (
  input  logic [METHOD_W-1:0] base_i,
  input  logic [COUNT_W-1:0]  idx_i,
  input  logic [MODE_W-1:0]   mode_i,
  output logic [METHOD_W-1:0] method_o
);

  logic [METHOD_W-1:0] idx_m;
  logic                not_first;

  // idx is narrowed or widened to the method width; wrap is modulo 2^METHOD_W
  generate
    if (COUNT_W >= METHOD_W) begin : g_narrow
      assign idx_m = idx_i[METHOD_W-1:0];
    end else begin : g_widen
      assign idx_m = {{(METHOD_W-COUNT_W){1'b0}}, idx_i};
    end
  endgenerate

  assign not_first = (idx_i != '0);

  always_comb begin
    unique case (mode_i)
      MODE_STEP: method_o = base_i + idx_m;
      MODE_ONCE: method_o = base_i + {{(METHOD_W-1){1'b0}}, not_first};
      default:   method_o = base_i;
    endcase
  end

endmodule

// File: rtl/cmd_burst_seq.sv
module cmd_burst_seq
  import cmd_expander_pkg::*;
#(
  parameter int COUNT_W = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hdr_fire_i,
  input  hdr_class_e         cls_i,
  input  logic [COUNT_W-1:0] count_i,
  input  logic               out_fire_i,
  output seq_state_e         state_o,
  output logic [COUNT_W-1:0] idx_o,
  output logic [COUNT_W-1:0] remain_o,
  output logic               err_o
);

  seq_state_e         state_q;
  logic [COUNT_W-1:0] idx_q, remain_q;
  logic               err_q;
  logic               last_w;

  assign last_w = (remain_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      remain_q <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (hdr_fire_i) begin
            unique case (cls_i)
              HC_BURST: begin
                state_q  <= ST_BURST;
                idx_q    <= '0;
                remain_q <= count_i - 1'b1;
              end
              HC_IMM: begin
                state_q  <= ST_IMM;
                idx_q    <= '0;
                remain_q <= '0;
              end
              HC_BAD:   err_q <= 1'b1;
              default:  ;
            endcase
          end
        end
        ST_BURST: begin
          if (out_fire_i) begin
            if (last_w) begin
              state_q <= ST_IDLE;
            end else begin
              idx_q    <= idx_q + 1'b1;
              remain_q <= remain_q - 1'b1;
            end
          end
        end
        ST_IMM: begin
          if (out_fire_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign idx_o    = idx_q;
  assign remain_o = remain_q;
  assign err_o    = err_q;

  // R5: countdown falls by one per accepted write, index rises by one
  p_countdown_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BURST && out_fire_i && !last_w)
      |=> (remain_q == $past(remain_q) - 1'b1) && (idx_q == $past(idx_q) + 1'b1));

  // R10: last accepted write returns the sequencer to idle
  p_last_ends_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && out_fire_i && last_w) |=> (state_q == ST_IDLE));

  // R7: an error pulse never coincides with an active burst
  p_err_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (state_q == ST_IDLE));

endmodule

// File: rtl/cmd_expander.sv
module cmd_expander
  import cmd_expander_pkg::*;
#(
  parameter int METHOD_W = 13,
  parameter int SUBCH_W  = 3,
  parameter int COUNT_W  = 13,
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hdr_valid_i,
  output logic                hdr_ready_o,
  input  logic [METHOD_W-1:0] hdr_method_i,
  input  logic [SUBCH_W-1:0]  hdr_subch_i,
  input  logic [COUNT_W-1:0]  hdr_count_i,
  input  logic [2:0]          hdr_mode_i,
  input  logic [IMM_W-1:0]    hdr_imm_i,
  input  logic                arg_valid_i,
  output logic                arg_ready_o,
  input  logic [DATA_W-1:0]   arg_data_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [METHOD_W-1:0] out_method_o,
  output logic [SUBCH_W-1:0]  out_subch_o,
  output logic [DATA_W-1:0]   out_data_o,
  output logic [COUNT_W-1:0]  out_remaining_o,
  output logic                err_o
);

  localparam int IMM_PAD = DATA_W - IMM_W;

  hdr_class_e          cls;
  seq_state_e          state;
  logic [COUNT_W-1:0]  idx, remain;
  logic                hdr_fire, out_fire;
  logic [METHOD_W-1:0] base_q;
  logic [SUBCH_W-1:0]  subch_q;
  logic [MODE_W-1:0]   mode_q;
  logic [IMM_W-1:0]    imm_q;
  logic [DATA_W-1:0]   imm_ext;

  assign hdr_ready_o = (state == ST_IDLE);
  assign hdr_fire    = hdr_valid_i && hdr_ready_o;
  assign out_fire    = out_valid_o && out_ready_i;

  cmd_hdr_classify #(.COUNT_W(COUNT_W)) u_classify (
    .mode_i  (hdr_mode_i),
    .count_i (hdr_count_i),
    .cls_o   (cls)
  );

  cmd_burst_seq #(.COUNT_W(COUNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hdr_fire_i (hdr_fire),
    .cls_i      (cls),
    .count_i    (hdr_count_i),
    .out_fire_i (out_fire),
    .state_o    (state),
    .idx_o      (idx),
    .remain_o   (remain),
    .err_o      (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      subch_q <= '0;
      mode_q  <= '0;
      imm_q   <= '0;
    end else if (hdr_fire) begin
      base_q  <= hdr_method_i;
      subch_q <= hdr_subch_i;
      mode_q  <= hdr_mode_i;
      imm_q   <= hdr_imm_i;
    end
  end

  cmd_method_step #(.METHOD_W(METHOD_W), .COUNT_W(COUNT_W)) u_step (
    .base_i   (base_q),
    .idx_i    (idx),
    .mode_i   (mode_q),
    .method_o (out_method_o)
  );

  generate
    if (IMM_PAD > 0) begin : g_imm_pad
      assign imm_ext = {{IMM_PAD{1'b0}}, imm_q};
    end else begin : g_imm_trunc
      assign imm_ext = imm_q[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (state)
      ST_BURST: begin
        out_valid_o = arg_valid_i;
        arg_ready_o = out_ready_i;
        out_data_o  = arg_data_i;
      end
      ST_IMM: begin
        out_valid_o = 1'b1;
        arg_ready_o = 1'b0;
        out_data_o  = imm_ext;
      end
      default: begin
        out_valid_o = 1'b0;
        arg_ready_o = 1'b0;
        out_data_o  = arg_data_i;
      end
    endcase
  end

  assign out_subch_o     = subch_q;
  assign out_remaining_o = remain;

  // R7: error pulse only follows an accepted header
  p_err_after_hdr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(hdr_valid_i && hdr_ready_o));

  // R6: immediate write is final and consumes no argument
  p_imm_final_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && state == ST_IMM) |-> (out_remaining_o == '0) && !arg_ready_o);

  // R11: a stalled write keeps its routing fields
  p_stall_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i)
      |=> $stable(out_method_o) && $stable(out_subch_o) && $stable(out_remaining_o));

  // R11: an argument is consumed only together with an accepted write
  p_arg_needs_out_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arg_valid_i && arg_ready_o) |-> (out_valid_o && out_ready_i));

endmodule

// File: tb/cmd_expander_tb.sv
module cmd_expander_tb;
  import cmd_expander_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int METHOD_W = 13;
  localparam int SUBCH_W  = 3;
  localparam int COUNT_W  = 13;
  localparam int DATA_W   = 32;
  localparam int IMM_W    = 13;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hdr_valid_i = 1'b0;
  logic hdr_ready_o;
  logic [METHOD_W-1:0] hdr_method_i = '0;
  logic [SUBCH_W-1:0]  hdr_subch_i = '0;
  logic [COUNT_W-1:0]  hdr_count_i = '0;
  logic [2:0]          hdr_mode_i = '0;
  logic [IMM_W-1:0]    hdr_imm_i = '0;
  logic arg_valid_i = 1'b0;
  logic arg_ready_o;
  logic [DATA_W-1:0]   arg_data_i = '0;
  logic out_valid_o;
  logic out_ready_i = 1'b1;
  logic [METHOD_W-1:0] out_method_o;
  logic [SUBCH_W-1:0]  out_subch_o;
  logic [DATA_W-1:0]   out_data_o;
  logic [COUNT_W-1:0]  out_remaining_o;
  logic err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_expander #(
    .METHOD_W(METHOD_W), .SUBCH_W(SUBCH_W), .COUNT_W(COUNT_W),
    .DATA_W(DATA_W), .IMM_W(IMM_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .hdr_valid_i(hdr_valid_i), .hdr_ready_o(hdr_ready_o),
    .hdr_method_i(hdr_method_i), .hdr_subch_i(hdr_subch_i),
    .hdr_count_i(hdr_count_i), .hdr_mode_i(hdr_mode_i), .hdr_imm_i(hdr_imm_i),
    .arg_valid_i(arg_valid_i), .arg_ready_o(arg_ready_o), .arg_data_i(arg_data_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_method_o(out_method_o), .out_subch_o(out_subch_o),
    .out_data_o(out_data_o), .out_remaining_o(out_remaining_o),
    .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Offer a header at a falling edge; returns at the falling edge after acceptance
  task automatic send_hdr(input logic [METHOD_W-1:0] m, input logic [SUBCH_W-1:0] s,
                          input logic [COUNT_W-1:0] c, input logic [2:0] md,
                          input logic [IMM_W-1:0] imm);
    hdr_method_i = m; hdr_subch_i = s; hdr_count_i = c; hdr_mode_i = md; hdr_imm_i = imm;
    hdr_valid_i = 1'b1;
    #1;
    check("R10 hdr_ready idle", hdr_ready_o, 1);
    @(posedge clk);
    @(negedge clk);
    hdr_valid_i = 1'b0;
  endtask

  // Offer one argument with downstream ready; check the write it produces
  task automatic feed(input string req, input logic [METHOD_W-1:0] em,
                      input logic [COUNT_W-1:0] er, input logic [SUBCH_W-1:0] es,
                      input logic [DATA_W-1:0] d);
    arg_valid_i = 1'b1; arg_data_i = d; out_ready_i = 1'b1;
    #1;
    check({req, " valid"}, out_valid_o, 1);
    check({req, " method"}, out_method_o, em);
    check("R5 remaining", out_remaining_o, er);
    check("R12 subch", out_subch_o, es);
    check({req, " data"}, out_data_o, d);
    check("R10 hdr blocked", hdr_ready_o, 0);
    @(posedge clk);
    @(negedge clk);
    arg_valid_i = 1'b0;
  endtask

  task automatic expect_idle(input string req);
    #1;
    check({req, " hdr_ready back"}, hdr_ready_o, 1);
    check({req, " no write"}, out_valid_o, 0);
  endtask

  task automatic t_reset;
    #1;
    check("R1 hdr_ready", hdr_ready_o, 1);
    check("R1 out_valid", out_valid_o, 0);
    check("R1 arg_ready", arg_ready_o, 0);
    check("R1 err", err_o, 0);
  endtask

  task automatic t_step;
    send_hdr(13'd100, 3'd2, 13'd4, MODE_STEP, '0);
    for (int i = 0; i < 4; i++)
      feed("R2 step", 13'(100 + i), 13'(4 - i - 1), 3'd2, 32'hA000_0000 + i);
    expect_idle("R10 step");
  endtask

  task automatic t_step_wrap;
    send_hdr(13'h1FFE, 3'd7, 13'd4, MODE_STEP, '0);
    for (int i = 0; i < 4; i++) begin
      logic [METHOD_W-1:0] m;
      m = 13'h1FFE + 13'(i);
      feed("R2 wrap", m, 13'(3 - i), 3'd7, 32'h5500_0000 + i);
    end
    expect_idle("R10 wrap");
  endtask

  task automatic t_fixed;
    send_hdr(13'h045, 3'd1, 13'd3, MODE_FIXED, '0);
    for (int i = 0; i < 3; i++)
      feed("R3 fixed", 13'h045, 13'(2 - i), 3'd1, 32'hB0B0_0000 + i);
    expect_idle("R10 fixed");
  endtask

  task automatic t_once;
    send_hdr(13'h0E00, 3'd5, 13'd5, MODE_ONCE, '0);
    for (int i = 0; i < 5; i++)
      feed("R4 once", (i == 0) ? 13'h0E00 : 13'h0E01, 13'(4 - i), 3'd5, 32'hC000_0000 + i);
    expect_idle("R10 once");
    send_hdr(13'h0E24, 3'd0, 13'd1, MODE_ONCE, '0);
    feed("R4 once single", 13'h0E24, 13'd0, 3'd0, 32'hDEAD_BEEF);
    expect_idle("R10 once single");
  endtask

  task automatic t_imm;
    send_hdr(13'h0123, 3'd4, 13'd9, MODE_IMM, 13'h1ABC);
    arg_valid_i = 1'b1; arg_data_i = 32'hFFFF_FFFF; out_ready_i = 1'b1;
    #1;
    check("R6 imm valid", out_valid_o, 1);
    check("R6 imm data", out_data_o, 32'h0000_1ABC);
    check("R6 imm remaining", out_remaining_o, 0);
    check("R6 imm method", out_method_o, 13'h0123);
    check("R6 imm no arg", arg_ready_o, 0);
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R6 single write", out_valid_o, 0);
    check("R6 arg untouched", arg_ready_o, 0);
    check("R10 imm done", hdr_ready_o, 1);
    arg_valid_i = 1'b0;
  endtask

  task automatic t_bad(input string req, input logic [2:0] md, input logic [COUNT_W-1:0] c);
    send_hdr(13'h0077, 3'd3, c, md, '0);
    arg_valid_i = 1'b1; arg_data_i = 32'h1234_5678;
    #1;
    check({req, " err pulse"}, err_o, 1);
    check({req, " no write"}, out_valid_o, 0);
    check({req, " no arg"}, arg_ready_o, 0);
    @(negedge clk);
    #1;
    check({req, " err one cycle"}, err_o, 0);
    check({req, " still no arg"}, arg_ready_o, 0);
    check({req, " hdr_ready"}, hdr_ready_o, 1);
    arg_valid_i = 1'b0;
  endtask

  task automatic t_empty(input logic [2:0] md);
    send_hdr(13'h0300, 3'd6, 13'd0, md, '0);
    arg_valid_i = 1'b1;
    #1;
    check("R9 no err", err_o, 0);
    check("R9 no write", out_valid_o, 0);
    check("R9 no arg", arg_ready_o, 0);
    check("R9 hdr_ready", hdr_ready_o, 1);
    arg_valid_i = 1'b0;
  endtask

  task automatic t_stall;
    send_hdr(13'h0200, 3'd3, 13'd3, MODE_STEP, '0);
    feed("R2 pre-stall", 13'h0200, 13'd2, 3'd3, 32'h0000_0001);
    arg_valid_i = 1'b1; arg_data_i = 32'h0000_0002; out_ready_i = 1'b0;
    hdr_valid_i = 1'b1; hdr_mode_i = MODE_FIXED; hdr_count_i = 13'd1;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R11 arg held", arg_ready_o, 0);
      check("R11 method held", out_method_o, 13'h0201);
      check("R11 remaining held", out_remaining_o, 13'd1);
      check("R10 hdr blocked in stall", hdr_ready_o, 0);
      @(negedge clk);
    end
    hdr_valid_i = 1'b0;
    out_ready_i = 1'b1;
    feed("R11 resume", 13'h0201, 13'd1, 3'd3, 32'h0000_0002);
    feed("R11 resume", 13'h0202, 13'd0, 3'd3, 32'h0000_0003);
    expect_idle("R10 stall");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_step();
    t_step_wrap();
    t_fixed();
    t_once();
    t_imm();
    t_bad("R7 mode0", 3'd0, 13'd2);
    t_bad("R7 mode6", 3'd6, 13'd1);
    t_bad("R8 once zero", MODE_ONCE, 13'd0);
    t_empty(MODE_STEP);
    t_empty(MODE_FIXED);
    t_stall();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule